// File: doc/BRIEF.md
# Sequential 8x8 Multiply Execution Unit

This unit carries out the single-byte inherent multiply instruction of a small 8-bit accumulator CPU core. The decoder raises an issue strobe together with the fetched opcode and the current accumulator, index and condition-code values. If the opcode is the multiply encoding and the unit is idle, it captures both operands and the flags. It then forms the unsigned 16-bit product with an iterative shift-and-add datapath that handles one multiplier bit per clock.

The product is returned split across two registers: the index register takes the upper byte and the accumulator takes the lower byte. The condition codes come back with the half-carry and carry flags cleared and every other bit as it was at issue. The core treats `done_o` as the write enable for all three registers. The unit holds `busy_o` so that the core stalls for the full instruction time. From the issue cycle to the done cycle inclusive, the instruction takes eleven clock cycles.

Top module: `mul8_seq_unit`

## Requirements
- R1: When `done_o` is high, `{idx_o, acc_o}` equals the unsigned product of the index and accumulator values captured at acceptance.
- R2: `idx_o` carries bits 15:8 of the product and `acc_o` carries bits 7:0.
- R3: When `done_o` is high, the half-carry flag at bit 4 of `ccr_o` is 0.
- R4: When `done_o` is high, the carry flag at bit 0 of `ccr_o` is 0.
- R5: When `done_o` is high, bits 7:5 and 3:1 of `ccr_o` equal the same bits of `ccr_i` sampled at acceptance, which includes the interrupt mask at bit 3, the negative flag at bit 2 and the zero flag at bit 1.
- R6: An issue is accepted only when `opcode_i` is 0x42. With any other opcode, `busy_o` stays low and no `done_o` pulse follows.
- R7: `done_o` is a single-cycle pulse that goes high exactly 10 rising edges after the edge that accepts the issue, so the issue cycle and the done cycle span 11 cycles.
- R8: An issue presented while `busy_o` is high is ignored. It neither restarts the timing nor replaces the captured operands or flags.
- R9: A synchronous active-high `rst` forces `busy_o` and `done_o` low on the next edge and abandons any operation in progress.
- R10: `busy_o` rises on the edge after acceptance, stays high through the done cycle, and falls on the following edge. From that cycle on, a new issue is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Instruction issue strobe from the decoder |
| opcode_i | input | 8 | Opcode presented with the issue strobe |
| acc_i | input | 8 | Current accumulator value |
| idx_i | input | 8 | Current index register value |
| ccr_i | input | 8 | Current condition-code register |
| busy_o | output | 1 | Operation in progress; core must stall |
| done_o | output | 1 | One-cycle write-back enable |
| acc_o | output | 8 | Low product byte for the accumulator |
| idx_o | output | 8 | High product byte for the index register |
| ccr_o | output | 8 | Updated condition-code register |

## Verification
The assertions assume that `rst` is high at time zero. They also assume that `issue_i`, `opcode_i` and the operand and flag inputs hold settled, known values at each rising edge, because the unit and the checker both capture them only on the accepting edge. The bench meets this by changing every input one nanosecond after a rising edge. It also holds reset for several cycles before the first issue. While the unit is busy, the bench deliberately drives new opcodes and operands, to show that the values captured at acceptance are the only ones used.

// File: rtl/mul8_pkg.sv
package mul8_pkg;

  localparam int CCR_W   = 8;
  localparam int H_POS   = 4;
  localparam int C_POS   = 0;

  localparam logic [CCR_W-1:0] CLR_MASK = CCR_W'((1 << H_POS) | (1 << C_POS));
  localparam logic [CCR_W-1:0] KEEP_MASK = ~CLR_MASK;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } mul_phase_e;

  // Flag update on completion: half-carry and carry cleared, rest kept.
  function automatic logic [CCR_W-1:0] mul_flags(input logic [CCR_W-1:0] old_ccr);
    logic [CCR_W-1:0] r;
    r = old_ccr;
    r[H_POS] = 1'b0;
    r[C_POS] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl #(
  parameter int LATENCY = 11,
  parameter int STEPS   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic step_o
);
  import mul8_pkg::*;

  localparam int CW = $clog2(LATENCY);
  localparam logic [CW-1:0] LAST   = CW'(LATENCY - 1);
  localparam logic [CW-1:0] PRELST = CW'(LATENCY - 2);
  localparam logic [CW-1:0] NSTEP  = CW'(STEPS);

  mul_phase_e      phase_q;
  logic [CW-1:0]   cnt_q;

  assign busy_o = (phase_q == PH_RUN);
  assign load_o = start_i && (phase_q == PH_IDLE);
  assign step_o = (phase_q == PH_RUN) && (cnt_q < NSTEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else if (phase_q == PH_IDLE) begin
      done_o <= 1'b0;
      if (start_i) begin
        phase_q <= PH_RUN;
        cnt_q   <= '0;
      end
    end else if (cnt_q == LAST) begin
      phase_q <= PH_IDLE;
      done_o  <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      done_o <= (cnt_q == PRELST);
    end
  end

endmodule

// File: rtl/mul_shift_add_dp.sv
module mul_shift_add_dp #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mplier_i,
  input  logic [W-1:0]   mcand_i,
  output logic [2*W-1:0] prod_o
);

  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;

  // One multiplier bit per call: conditional add into the upper half, then shift right.
  function automatic logic [2*W-1:0] shift_add(input logic [2*W-1:0] p,
                                               input logic [W-1:0]   m);
    logic [W:0] upper;
    upper = {1'b0, p[2*W-1:W]} + (p[0] ? {1'b0, m} : '0);
    return {upper, p[W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q  <= shift_add(prod_q, mcand_q);
    end
  end

  assign prod_o = prod_q;

endmodule

// File: rtl/mul_flag_merge.sv
module mul_flag_merge (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_i,
  input  logic [mul8_pkg::CCR_W-1:0] ccr_i,
  output logic [mul8_pkg::CCR_W-1:0] ccr_o
);
  import mul8_pkg::*;

  logic [CCR_W-1:0] ccr_q;

  always_ff @(posedge clk) begin
    if (rst)         ccr_q <= '0;
    else if (load_i) ccr_q <= ccr_i;
  end

  assign ccr_o = mul_flags(ccr_q);

endmodule

// File: rtl/mul8_seq_unit.sv
module mul8_seq_unit #(
  parameter int         DATA_W  = 8,
  parameter int         OPC_W   = 8,
  parameter logic [7:0] MUL_OPC = 8'h42,
  parameter int         LATENCY = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       issue_i,
  input  logic [OPC_W-1:0]           opcode_i,
  input  logic [DATA_W-1:0]          acc_i,
  input  logic [DATA_W-1:0]          idx_i,
  input  logic [mul8_pkg::CCR_W-1:0] ccr_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [DATA_W-1:0]          acc_o,
  output logic [DATA_W-1:0]          idx_o,
  output logic [mul8_pkg::CCR_W-1:0] ccr_o
);

  logic             opc_hit_w;
  logic             start_w;
  logic             accept_w;
  logic             step_w;
  logic [2*DATA_W-1:0] prod_w;

  assign opc_hit_w = (opcode_i == OPC_W'(MUL_OPC));
  assign start_w   = issue_i && opc_hit_w;

  mul_seq_ctrl #(.LATENCY(LATENCY), .STEPS(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_w),
    .busy_o(busy_o), .done_o(done_o), .load_o(accept_w), .step_o(step_w)
  );

  mul_shift_add_dp #(.W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .load_i(accept_w), .step_i(step_w),
    .mplier_i(acc_i), .mcand_i(idx_i), .prod_o(prod_w)
  );

  mul_flag_merge u_flags (
    .clk(clk), .rst(rst), .load_i(accept_w), .ccr_i(ccr_i), .ccr_o(ccr_o)
  );

  assign idx_o = prod_w[2*DATA_W-1:DATA_W];
  assign acc_o = prod_w[DATA_W-1:0];

endmodule

// File: rtl/mul8_seq_unit_chk.sv
module mul8_seq_unit_chk #(
  parameter int         W       = 8,
  parameter int         OPC_W   = 8,
  parameter logic [7:0] MUL_OPC = 8'h42,
  parameter int         LATENCY = 11
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       issue_i,
  input logic [OPC_W-1:0]           opcode_i,
  input logic [W-1:0]               acc_i,
  input logic [W-1:0]               idx_i,
  input logic [mul8_pkg::CCR_W-1:0] ccr_i,
  input logic                       busy_o,
  input logic                       done_o,
  input logic [W-1:0]               acc_o,
  input logic [W-1:0]               idx_o,
  input logic [mul8_pkg::CCR_W-1:0] ccr_o,
  input logic                       accept_w,
  input logic                       step_w
);
  import mul8_pkg::*;

  logic                 seen_acc;
  logic [W-1:0]         a_q, x_q;
  logic [CCR_W-1:0]     ccr_q;
  logic [2*W-1:0]       ref_prod;
  int                   cyc_q, steps_q;

  assign seen_acc = issue_i && (opcode_i == OPC_W'(MUL_OPC)) && !busy_o;
  assign ref_prod = {{W{1'b0}}, x_q} * {{W{1'b0}}, a_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= 0; steps_q <= 0;
      a_q <= '0; x_q <= '0; ccr_q <= '0;
    end else if (seen_acc) begin
      cyc_q <= 0; steps_q <= 0;
      a_q <= acc_i; x_q <= idx_i; ccr_q <= ccr_i;
    end else if (busy_o) begin
      cyc_q <= cyc_q + 1;
      if (step_w) steps_q <= steps_q + 1;
    end
  end

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ({idx_o, acc_o} == ref_prod));
  assert_steps_R1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (steps_q == W));
  assert_split_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (idx_o == ref_prod[2*W-1:W] && acc_o == ref_prod[W-1:0]));
  assert_hclr_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !ccr_o[H_POS]);
  assert_cclr_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !ccr_o[C_POS]);
  assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((ccr_o & KEEP_MASK) == (ccr_q & KEEP_MASK)));
  assert_opcode_R6: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !busy_o && opcode_i != OPC_W'(MUL_OPC)) |=> !busy_o);
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cyc_q == LATENCY - 1));
  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> busy_o);
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o));
  assert_start_R10: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> (busy_o && !done_o));
  assert_cover_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_o);
  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o);
  assert_stepbusy_R10: assert property (@(posedge clk) disable iff (rst)
    step_w |-> busy_o);

endmodule

bind mul8_seq_unit mul8_seq_unit_chk #(
  .W(DATA_W), .OPC_W(OPC_W), .MUL_OPC(MUL_OPC), .LATENCY(LATENCY)
) u_chk (
  .clk(clk), .rst(rst), .issue_i(issue_i), .opcode_i(opcode_i),
  .acc_i(acc_i), .idx_i(idx_i), .ccr_i(ccr_i),
  .busy_o(busy_o), .done_o(done_o), .acc_o(acc_o), .idx_o(idx_o), .ccr_o(ccr_o),
  .accept_w(accept_w), .step_w(step_w)
);

// File: tb/test_mul8_seq_unit.sv
`timescale 1ns/1ps
module test_mul8_seq_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue_i = 1'b0;
  logic [7:0] opcode_i = 8'h00, acc_i = 8'h00, idx_i = 8'h00, ccr_i = 8'h00;
  logic       busy_o, done_o;
  logic [7:0] acc_o, idx_o, ccr_o;

  int checks = 0;
  int fails  = 0;
  string phase = "reset";

  // reference model state
  bit   m_busy = 0, m_done = 0;
  int   m_cnt = 0;
  int   m_a = 0, m_x = 0, m_ccr = 0;

  always #2.5 clk = ~clk;

  mul8_seq_unit i_mul8_seq_unit (
    .clk(clk), .rst(rst), .issue_i(issue_i), .opcode_i(opcode_i),
    .acc_i(acc_i), .idx_i(idx_i), .ccr_i(ccr_i),
    .busy_o(busy_o), .done_o(done_o), .acc_o(acc_o), .idx_o(idx_o), .ccr_o(ccr_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual=%0h expected=%0h", req, phase, what, act, exp);
    end
  endtask

  // Behavioural model, advanced once per rising edge from the bench's own inputs.
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
    end else if (m_busy) begin
      if (m_cnt == 10) begin
        m_busy = 0; m_done = 0;
      end else begin
        m_cnt = m_cnt + 1;
        m_done = (m_cnt == 10);
      end
    end else if (issue_i && opcode_i == 8'h42) begin
      m_busy = 1; m_done = 0; m_cnt = 0;
      m_a = acc_i; m_x = idx_i; m_ccr = ccr_i;
    end
  end

  // Compare on every clock, away from the rising edge.
  always @(negedge clk) begin
    int prod;
    chk(busy_o == m_busy, "R10", "busy_o", busy_o, m_busy);
    chk(done_o == m_done, "R7", "done_o", done_o, m_done);
    if (m_done) begin
      prod = m_x * m_a;
      chk({idx_o, acc_o} == prod[15:0], "R1", "product", {idx_o, acc_o}, prod);
      chk(idx_o == prod[15:8], "R2", "high byte", idx_o, prod[15:8]);
      chk(acc_o == prod[7:0], "R2", "low byte", acc_o, prod[7:0]);
      chk(ccr_o[4] == 1'b0, "R3", "half-carry", ccr_o[4], 0);
      chk(ccr_o[0] == 1'b0, "R4", "carry", ccr_o[0], 0);
      chk((ccr_o & 8'hEE) == (m_ccr & 8'hEE), "R5", "kept flags",
          ccr_o & 8'hEE, m_ccr & 8'hEE);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_idle();
    while (m_busy) tick();
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] a,
                        input logic [7:0] x, input logic [7:0] f);
    issue_i = 1'b1; opcode_i = op; acc_i = a; idx_i = x; ccr_i = f;
    tick();
    issue_i = 1'b0; acc_i = $urandom; idx_i = $urandom; ccr_i = $urandom;
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] corner [6];
    corner = '{8'h00, 8'h01, 8'hFF, 8'h80, 8'h7F, 8'h10};
    repeat (4) tick();
    rst = 1'b0;
    @(negedge clk);
    phase = "reset state";
    chk(busy_o == 1'b0, "R9", "busy after reset", busy_o, 0);
    chk(done_o == 1'b0, "R9", "done after reset", done_o, 0);
    tick();

    phase = "R1 corners";
    foreach (corner[i]) begin
      for (int j = 0; j < 6; j++) begin
        run_op(8'h42, corner[i], corner[j], (i + j) % 2 ? 8'hFF : 8'h00);
        tick();
      end
    end

    phase = "R5 flag patterns";
    run_op(8'h42, 8'hFF, 8'hFF, 8'hAA);
    run_op(8'h42, 8'h12, 8'h34, 8'h55);
    run_op(8'h42, 8'h00, 8'h00, 8'h1F);

    phase = "R1 random";
    for (int k = 0; k < 40; k++) run_op(8'h42, $urandom, $urandom, $urandom);

    phase = "R6 wrong opcode";
    for (int k = 0; k < 4; k++) begin
      issue_i = 1'b1; opcode_i = (k == 0) ? 8'h43 : (k == 1) ? 8'h00 : (k == 2) ? 8'hC2 : 8'h40;
      acc_i = 8'h11; idx_i = 8'h22;
      tick();
      issue_i = 1'b0;
      @(negedge clk);
      chk(busy_o == 1'b0, "R6", "busy after foreign opcode", busy_o, 0);
      repeat (12) tick();
    end

    phase = "R8 issue while busy";
    issue_i = 1'b1; opcode_i = 8'h42; acc_i = 8'h0F; idx_i = 8'h0E; ccr_i = 8'h0B;
    tick();
    acc_i = 8'hF0; idx_i = 8'hE0; ccr_i = 8'hE4;
    repeat (6) tick();
    issue_i = 1'b0;
    wait_idle();

    phase = "R10 back-to-back";
    issue_i = 1'b1; opcode_i = 8'h42; acc_i = 8'hC3; idx_i = 8'h5A; ccr_i = 8'hFF;
    repeat (23) tick();
    issue_i = 1'b0;
    wait_idle();

    phase = "R9 reset mid-operation";
    issue_i = 1'b1; opcode_i = 8'h42; acc_i = 8'h99; idx_i = 8'h77;
    tick();
    issue_i = 1'b0;
    repeat (4) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R9", "idle after reset", {busy_o, done_o}, 0);
    repeat (12) tick();
    run_op(8'h42, 8'hFE, 8'hFD, 8'h08);
    repeat (3) tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule